// File: doc/BRIEF.md
# Prescaled Free-Running Timer

A 16-bit up-counter that never stops, advanced once per prescaled tick. A two-bit select picks a divide ratio of 1, 4, 8 or 16 system clocks per count. When the count passes from its all-ones value to zero, a sticky wrap flag is raised. Each of a set of compare channels holds a programmed value. The channel raises its own sticky flag on the increment that brings the count to that value, so software can measure elapsed time against a target.

A second, independent timebase runs on the raw clock and raises a sticky periodic flag every 2^13, 2^14, 2^15 or 2^16 clocks, depending on a two-bit rate code. Software reaches everything through a small register bus:
- it reads the count;
- it programs the divide and rate codes, the enables and the compare values;
- it reads the flags and clears them by writing ones.

A single interrupt output is active while any enabled flag is set.

Top module: `prescaled_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the count, control word, flags, enables and compare values read as 0 and `irq` is 0.
- R2: The count rises by exactly 1 on each prescaled tick and never otherwise; it wraps from 0xFFFF to 0. The prescale code in control bits [1:0] selects 1, 4, 8 or 16 clocks per tick for codes 00, 01, 10 and 11.
- R3: Flag bit 0 (wrap) is set on the tick that takes the count from 0xFFFF to 0.
- R4: Flag bit 2+k is set on the tick at which the count becomes equal to compare register k (two channels by default).
- R5: Flags are sticky: a set flag stays set until cleared. A set event and a clear of the same bit in the same cycle leave the bit set.
- R6: Writing the flag register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R7: Flag bit 1 (periodic) is set once every 2^(13+r) clocks, where r is the rate code in control bits [3:2]. The period does not depend on the prescale code.
- R8: `irq` is 1 exactly when some flag bit is set together with the matching bit of the enable register, which uses the same bit layout as the flag register.
- R9: A control write that changes the prescale code restarts the divider. With the new divisor d, the next increment comes d clocks after that write's clock edge.
- R10: The register map is as follows:
  - address 0: count, read only; writes are ignored;
  - address 1: control;
  - address 2: flags;
  - address 3: enables;
  - address 4+k: compare k.

  Reads return the addressed register when `bus_sel` is 1 and return 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wdata | input | CNT_W (16) | Write data |
| bus_rdata | output | CNT_W (16) | Read data of the addressed register |
| irq | output | 1 | Interrupt request, OR of enabled flags |

## Verification
Software's clear of a flag can land on the same clock edge as the hardware event that sets it. The bench provokes this with the periodic flag. It uses its own model of the free-running timebase to place a write that clears bit 1 exactly on the edge where the timebase completes a period. It then judges the result by reading the flag back as still set. Wrap and compare events can also share an edge when a compare register holds 0, and the per-cycle comparison against the model covers that case as well.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   // register addresses
   localparam int A_COUNT  = 0;
   localparam int A_CTRL   = 1;
   localparam int A_FLAGS  = 2;
   localparam int A_ENABLE = 3;
   localparam int A_CMP0   = 4;

   // flag / enable bit positions
   localparam int F_OVF  = 0;
   localparam int F_RTI  = 1;
   localparam int F_CMP0 = 2;

   // control word
   typedef struct packed {
      logic [1:0] rate;
      logic [1:0] psel;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
   parameter int PW = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] sel,
   input  logic       restart,
   output logic       tick
);

   if (PW < 4) begin : g_bad_pw
      $error("ptmr_prescaler: PW must hold a divide by 16");
   end

   logic [PW-1:0] div_q;
   logic [PW-1:0] last;

   always_comb begin
      case (sel)
         2'd0:    last = '0;
         2'd1:    last = PW'(3);
         2'd2:    last = PW'(7);
         default: last = PW'(15);
      endcase
   end

   assign tick = !restart && (div_q == last);

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q <= '0;
      end else if (restart || tick) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + PW'(1);
      end
   end

endmodule

// File: rtl/ptmr_rti.sv
module ptmr_rti #(
   parameter int BASE_LOG2 = 13
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] rate,
   output logic       tick
);

   localparam int TW = BASE_LOG2 + 3;

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("ptmr_rti: BASE_LOG2 must be positive");
   end

   logic [TW-1:0] tb_q;
   logic [TW-1:0] mask;

   // rate 3 uses all TW bits, each lower code drops one top bit
   assign mask = {TW{1'b1}} >> (2'd3 - rate);
   assign tick = &(tb_q | ~mask);

   always_ff @(posedge clk) begin
      if (rst) begin
         tb_q <= '0;
      end else begin
         tb_q <= tb_q + TW'(1);
      end
   end

endmodule

// File: rtl/ptmr_compare.sv
module ptmr_compare #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         cnt_step,
   input  logic [W-1:0] cnt_next,
   output logic [W-1:0] value,
   output logic         hit
);

   always_ff @(posedge clk) begin
      if (rst) begin
         value <= '0;
      end else if (load) begin
         value <= load_val;
      end
   end

   assign hit = cnt_step && (cnt_next == value);

endmodule

// File: rtl/ptmr_flags.sv
module ptmr_flags #(
   parameter int NF = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NF-1:0] set,
   input  logic [NF-1:0] clr,
   output logic [NF-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         q <= (q & ~clr) | set;
      end
   end

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
   import ptmr_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int N_CMP     = 2,
   parameter int ADDR_W    = 3,
   parameter int RTI_BASE  = 13,
   parameter int PRE_W     = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq
);

   localparam int NF = F_CMP0 + N_CMP;

   if (N_CMP < 1) begin : g_bad_ncmp
      $error("prescaled_timer: need at least one compare channel");
   end
   if (CNT_W < NF || CNT_W < CTRL_W) begin : g_bad_cntw
      $error("prescaled_timer: CNT_W too narrow for flag or control word");
   end
   if ((1 << ADDR_W) < A_CMP0 + N_CMP) begin : g_bad_addrw
      $error("prescaled_timer: ADDR_W too small for register map");
   end

   logic                         wr_en;
   logic                         ctrl_wr;
   logic                         psel_change;
   logic                         tick;
   logic                         rti_tick;
   ctrl_t                        ctrl_q;
   logic [CNT_W-1:0]             cnt_q;
   logic [CNT_W-1:0]             cnt_next;
   logic [NF-1:0]                en_q;
   logic [NF-1:0]                flags_q;
   logic [NF-1:0]                flag_set;
   logic [NF-1:0]                flag_clr;
   logic [N_CMP-1:0]             cmp_hit;
   logic [N_CMP-1:0][CNT_W-1:0]  cmp_vals;

   assign wr_en       = bus_sel && bus_wr;
   assign ctrl_wr     = wr_en && (bus_addr == ADDR_W'(A_CTRL));
   assign psel_change = ctrl_wr && (bus_wdata[1:0] != ctrl_q.psel);
   assign cnt_next    = cnt_q + CNT_W'(1);

   // control and enable registers
   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
         en_q   <= '0;
      end else begin
         if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         end
         if (wr_en && (bus_addr == ADDR_W'(A_ENABLE))) begin
            en_q <= bus_wdata[NF-1:0];
         end
      end
   end

   ptmr_prescaler #(.PW(PRE_W)) i_pre (
      .clk     (clk),
      .rst     (rst),
      .sel     (ctrl_q.psel),
      .restart (psel_change),
      .tick    (tick)
   );

   // main counter
   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_next;
      end
   end

   ptmr_rti #(.BASE_LOG2(RTI_BASE)) i_rti (
      .clk  (clk),
      .rst  (rst),
      .rate (ctrl_q.rate),
      .tick (rti_tick)
   );

   for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
      ptmr_compare #(.W(CNT_W)) i_cmp (
         .clk      (clk),
         .rst      (rst),
         .load     (wr_en && (bus_addr == ADDR_W'(A_CMP0 + k))),
         .load_val (bus_wdata),
         .cnt_step (tick),
         .cnt_next (cnt_next),
         .value    (cmp_vals[k]),
         .hit      (cmp_hit[k])
      );
   end

   always_comb begin
      flag_set                       = '0;
      flag_set[F_OVF]                = tick && (&cnt_q);
      flag_set[F_RTI]                = rti_tick;
      flag_set[F_CMP0 +: N_CMP]      = cmp_hit;
   end

   assign flag_clr = (wr_en && (bus_addr == ADDR_W'(A_FLAGS))) ? bus_wdata[NF-1:0] : '0;

   ptmr_flags #(.NF(NF)) i_flags (
      .clk (clk),
      .rst (rst),
      .set (flag_set),
      .clr (flag_clr),
      .q   (flags_q)
   );

   assign irq = |(flags_q & en_q);

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         if (bus_addr == ADDR_W'(A_COUNT)) begin
            bus_rdata = cnt_q;
         end
         if (bus_addr == ADDR_W'(A_CTRL)) begin
            bus_rdata = CNT_W'(ctrl_q);
         end
         if (bus_addr == ADDR_W'(A_FLAGS)) begin
            bus_rdata = CNT_W'(flags_q);
         end
         if (bus_addr == ADDR_W'(A_ENABLE)) begin
            bus_rdata = CNT_W'(en_q);
         end
         for (int k = 0; k < N_CMP; k++) begin
            if (bus_addr == ADDR_W'(A_CMP0 + k)) begin
               bus_rdata = cmp_vals[k];
            end
         end
      end
   end

endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
   import ptmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int N_CMP  = 2,
   parameter int ADDR_W = 3
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        bus_sel,
   input logic                        bus_wr,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [CNT_W-1:0]            bus_wdata,
   input logic [CNT_W-1:0]            cnt,
   input logic [F_CMP0+N_CMP-1:0]     flags,
   input logic [F_CMP0+N_CMP-1:0]     en,
   input logic [N_CMP-1:0][CNT_W-1:0] cmp_vals,
   input logic                        irq
);

   localparam int NF = F_CMP0 + N_CMP;

   assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
      (cnt != $past(cnt)) |-> (cnt == $past(cnt) + CNT_W'(1)));

   assert_wrap_sets_ovf_R3: assert property (@(posedge clk) disable iff (rst)
      (($past(cnt) == {CNT_W{1'b1}}) && (cnt == '0)) |-> flags[F_OVF]);

   for (genvar k = 0; k < N_CMP; k++) begin : g_cmp_chk
      assert_cmp_match_R4: assert property (@(posedge clk) disable iff (rst)
         ((cnt != $past(cnt)) && (cnt == $past(cmp_vals[k]))) |-> flags[F_CMP0 + k]);
   end

   for (genvar i = 0; i < NF; i++) begin : g_sticky_chk
      assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
         ($past(flags[i]) &&
          !$past(bus_sel && bus_wr && (bus_addr == ADDR_W'(A_FLAGS)) && bus_wdata[i]))
         |-> flags[i]);
   end

   assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
      (en == '0) |-> !irq);

   assert_irq_idle_R8: assert property (@(posedge clk) disable iff (rst)
      (flags == '0) |-> !irq);

endmodule

bind prescaled_timer ptmr_checker #(
   .CNT_W  (CNT_W),
   .N_CMP  (N_CMP),
   .ADDR_W (ADDR_W)
) i_ptmr_checker (
   .clk       (clk),
   .rst       (rst),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .cnt       (cnt_q),
   .flags     (flags_q),
   .en        (en_q),
   .cmp_vals  (cmp_vals),
   .irq       (irq)
);

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_sel = 1'b1;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        irq;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;

   // reference model state
   int m_cnt = 0, m_pdiv = 0, m_rti = 0, m_psel = 0, m_rsel = 0;
   int m_flags = 0, m_en = 0;
   int m_cmp [2] = '{0, 0};
   int md_div, md_per, md_set, md_clr;
   bit md_wr, md_chg, md_tick;

   prescaled_timer i_prescaled_timer (
      .clk       (clk),
      .rst       (rst),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // behavioural model, updated on every rising edge
   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_cnt = 0; m_pdiv = 0; m_rti = 0; m_psel = 0; m_rsel = 0;
         m_flags = 0; m_en = 0; m_cmp[0] = 0; m_cmp[1] = 0;
      end else begin
         md_wr   = bus_sel && bus_wr;
         md_div  = (m_psel == 0) ? 1 : (m_psel == 1) ? 4 : (m_psel == 2) ? 8 : 16;
         md_chg  = md_wr && (bus_addr == 3'd1) && (int'(bus_wdata[1:0]) != m_psel);
         md_tick = !md_chg && (m_pdiv == md_div - 1);
         md_per  = 1 << (13 + m_rsel);
         md_set  = 0;
         if (md_tick && m_cnt == 65535) md_set |= 1;
         if ((m_rti % md_per) == md_per - 1) md_set |= 2;
         for (int k = 0; k < 2; k++)
            if (md_tick && ((m_cnt + 1) % 65536) == m_cmp[k]) md_set |= (4 << k);
         md_clr  = (md_wr && bus_addr == 3'd2) ? int'(bus_wdata[3:0]) : 0;
         m_flags = ((m_flags & ~md_clr) | md_set) & 15;
         if (md_tick) m_cnt = (m_cnt + 1) % 65536;
         m_pdiv  = (md_chg || md_tick) ? 0 : m_pdiv + 1;
         m_rti   = (m_rti + 1) % 65536;
         if (md_wr) begin
            case (bus_addr)
               3'd1: begin m_psel = int'(bus_wdata[1:0]); m_rsel = int'(bus_wdata[3:2]); end
               3'd3: m_en = int'(bus_wdata[3:0]);
               3'd4: m_cmp[0] = int'(bus_wdata);
               3'd5: m_cmp[1] = int'(bus_wdata);
               default: ;
            endcase
         end
      end
   end

   function automatic int model_rdata();
      if (!bus_sel) return 0;
      case (bus_addr)
         3'd0: return m_cnt;
         3'd1: return (m_rsel << 2) | m_psel;
         3'd2: return m_flags;
         3'd3: return m_en;
         3'd4: return m_cmp[0];
         3'd5: return m_cmp[1];
         default: return 0;
      endcase
   endfunction

   function automatic string addr_tag();
      case (bus_addr)
         3'd0: return "R2 count";
         3'd2: return "R5 flags";
         3'd4, 3'd5: return "R4 compare";
         default: return "R10 register";
      endcase
   endfunction

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (cyc > 0) begin
         chk(addr_tag(), int'(bus_rdata), model_rdata());
         chk("R8 irq", int'(irq), int'((m_flags & m_en) != 0));
      end
   end

   task automatic wr_reg(input int a, input int d);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = 3'd0;
   endtask

   task automatic rd_reg(input int a, output int d);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_addr = 3'(a);
      @(negedge clk);
      d = int'(bus_rdata);
   endtask

   task automatic count_gap(input int gap, output int diff);
      int a, b;
      rd_reg(0, a);
      repeat (gap - 1) @(posedge clk);
      rd_reg(0, b);
      diff = (b - a + 65536) % 65536;
   endtask

   task automatic wait_irq(output int t);
      @(negedge clk);
      while (!irq) @(negedge clk);
      t = cyc;
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      int v, t1, t2;

      // R1: reset state
      repeat (3) @(posedge clk);
      rd_reg(0, v); chk("R1 count in reset", v, 0);
      rd_reg(2, v); chk("R1 flags in reset", v, 0);
      rd_reg(1, v); chk("R1 control in reset", v, 0);
      chk("R1 irq in reset", int'(irq), 0);
      @(posedge clk); #1; rst = 1'b0;
      @(negedge clk);
      chk("R1 count after reset", int'(bus_rdata), 0);

      // R4 / R8 / R6: compare channels, enable gating, clear by ones
      wr_reg(4, 16'h0040);
      wr_reg(5, 16'h0300);
      do rd_reg(0, v); while (v < 16'h0048);
      rd_reg(2, v); chk("R4 compare 0 flag", v & 4, 4);
      chk("R8 irq masked", int'(irq), 0);
      wr_reg(3, 4);
      @(negedge clk); chk("R8 irq enabled", int'(irq), 1);
      wr_reg(2, 0);
      rd_reg(2, v); chk("R6 zero write keeps flag", v & 4, 4);
      wr_reg(2, 4);
      rd_reg(2, v); chk("R6 one write clears flag", v & 4, 0);
      chk("R8 irq after clear", int'(irq), 0);

      // R2: divide by 1
      count_gap(64, v); chk("R2 divide by 1", v, 64);
      do rd_reg(0, v); while (v < 16'h0308);
      rd_reg(2, v); chk("R4 compare 1 flag", v & 8, 8);

      // R7: periodic flag at rate 00
      wr_reg(3, 2);
      wr_reg(2, 15);
      wait_irq(t1);
      wr_reg(2, 2);
      wait_irq(t2);
      chk("R7 period rate 00", t2 - t1, 8192);
      wr_reg(3, 0);

      // R3: wrap flag
      do rd_reg(2, v); while ((v & 1) == 0);
      rd_reg(0, v); chk("R3 wrap seen near zero", int'(v < 16), 1);
      repeat (20) @(posedge clk);
      rd_reg(2, v); chk("R5 wrap flag sticky", v & 1, 1);

      // R5: clear coinciding with periodic set
      wr_reg(2, 2);
      rd_reg(2, v); chk("R6 periodic flag cleared", v & 2, 0);
      forever begin
         @(posedge clk); #1;
         if ((m_rti % 8192) == 8191) break;
      end
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 16'd2;
      @(posedge clk); #1;
      bus_wr = 1'b0;
      @(negedge clk);
      chk("R5 set beats same-cycle clear", int'(bus_rdata) & 2, 2);

      // R2 / R9: other divisors and divider restart
      wr_reg(1, 1);
      count_gap(64, v);  chk("R2 divide by 4", v, 16);
      wr_reg(1, 2);
      count_gap(128, v); chk("R2 divide by 8", v, 16);
      @(posedge clk); #1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 16'd3;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = 3'd0;
      @(negedge clk);
      t1 = int'(bus_rdata);
      repeat (15) @(negedge clk);
      chk("R9 no step before 16 clocks", int'(bus_rdata), t1);
      @(negedge clk);
      chk("R9 step on 16th clock", int'(bus_rdata), (t1 + 1) % 65536);
      count_gap(256, v); chk("R2 divide by 16", v, 16);

      // R7: periodic flag at rate 01, prescaler at 16
      wr_reg(1, 7);
      wr_reg(3, 2);
      wr_reg(2, 15);
      wait_irq(t1);
      wr_reg(2, 2);
      wait_irq(t2);
      chk("R7 period rate 01", t2 - t1, 16384);

      // R10: map, read-only count, deselected read
      rd_reg(1, v); chk("R10 control readback", v, 7);
      rd_reg(0, t1);
      wr_reg(0, 16'h1234);
      rd_reg(0, t2);
      chk("R10 count write ignored", int'(((t2 - t1 + 65536) % 65536) <= 2), 1);
      @(posedge clk); #1; bus_sel = 1'b0;
      @(negedge clk);
      chk("R10 deselected read is zero", int'(bus_rdata), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule